// File: doc/BRIEF.md
# Dual-Card Serial Command Decoder

This block is the control front end of an interface that serves two card slots. A host talks to it as the master on a four-wire serial bus. Each chip-select frame carries exactly one byte. The top three bits are a command and the low five bits are a data value. The block decodes the byte and writes the data into the configuration register of card A or card B, or into a small global configuration. Two such blocks can hang on one bus. A strap input gives each block its address: one command bit is compared against the strap, so each block answers only its own half of the card-command space.

In the same frame, the block shifts a status byte back to the host. That byte is the status input captured when chip select falls, and it goes out most significant bit first. The SPI pins are oversampled by the system clock, so the serial clock may idle low or high. A decoded byte takes effect only when chip select returns high, and only if exactly eight bits were clocked in. An interrupt output tells the host that the status has moved away from the last value it fully read.

Top module: `dcsc_cmd_decoder`

## Requirements
- R1: After reset, both card registers, card_sel, sync_mode, det_pol, spi_special, slope_fast, spi_miso_oe and irq are all 0.
- R2: A command with byte bit 7 = 0 and byte bit 6 equal to strap_addr writes byte bits 4..0 to the card A register when byte bit 5 = 0 and to the card B register when byte bit 5 = 1. It also sets card_sel to byte bit 5 and clears sync_mode.
- R3: A command with byte bit 7 = 0 and byte bit 6 different from strap_addr changes no output.
- R4: Commands 110 and 111 (byte bits 7..5) write the data to card A or card B, chosen by bit 5, whatever strap_addr is. They set card_sel to bit 5 and set sync_mode to 1.
- R5: Command 100 changes no output.
- R6: Command 101 sets det_pol from data bit 0, spi_special from data bit 1 and slope_fast from data bit 2, whatever strap_addr is. Both card registers, card_sel and sync_mode are left unchanged.
- R7: A frame that clocks in any number of rising serial-clock edges other than 8 is discarded. No configuration output changes, and the frame does not count as a status read.
- R8: spi_miso_oe is 1 only while chip select is low. spi_miso presents the status captured at the chip-select fall, bit 7 first. A new bit appears after each falling serial-clock edge that follows a rising edge. This holds with the serial clock idling either low or high.
- R9: irq is 1 exactly when status_in differs from the status byte delivered by the last complete 8-bit frame; that reference is 0 after reset. A complete frame clears irq only if status_in still equals the captured byte.
- R10: No configuration output changes while chip select is low, even after the eighth bit. The update happens only after chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, either idle level |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host, sampled on rising serial-clock edges |
| strap_addr | input | 1 | Board strap giving this device's address |
| status_in | input | 8 | Live status; bit 0 is the supply-fault flag |
| spi_miso | output | 1 | Serial status data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso; the pad is high impedance when 0 |
| card_a_cfg | output | 5 | Configuration register of card A |
| card_b_cfg | output | 5 | Configuration register of card B |
| card_sel | output | 1 | Card addressed by the last card write (0 = A, 1 = B) |
| sync_mode | output | 1 | 1 if the last card write used a synchronous-card command |
| det_pol | output | 1 | Card-detect switch polarity |
| spi_special | output | 1 | Special serial-mode select |
| slope_fast | output | 1 | Fast card-clock edge rate for both cards |
| irq | output | 1 | Status-change interrupt |

## Verification
A frame commit and a status change can land in the same system-clock cycle. The commit moves the interrupt reference while the comparison against the live status is being made. The bench provokes this by changing status_in in the middle of a frame, and also exactly as chip select rises. It then expects irq to stay high after the read, because the live status no longer matches the byte that was delivered. Random frames with random status values, both clock idle levels and odd bit counts then check that discarded frames leave the reference alone.

// File: rtl/dcsc_pkg.sv
package dcsc_pkg;
  localparam int FRAME_BITS = 8;
  localparam int CMD_W      = 3;
  localparam int DATA_W     = FRAME_BITS - CMD_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 3'b100,
    CMD_GCFG = 3'b101
  } gcmd_e;

  typedef struct packed {
    logic slope_fast;
    logic spi_special;
    logic det_pol;
  } gcfg_t;
endpackage

// File: rtl/dcsc_sync.sv
module dcsc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcsc_spi_shifter.sv
module dcsc_spi_shifter #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_s,
  input  logic                  cs_n_s,
  input  logic                  mosi_s,
  input  logic [FRAME_BITS-1:0] status_in,
  output logic                  cs_active,
  output logic                  frame_ok,
  output logic [FRAME_BITS-1:0] rx_byte,
  output logic [FRAME_BITS-1:0] snap,
  output logic                  miso,
  output logic                  miso_oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                  sck_d, cs_n_d, seen_rise;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] rx_q, tx_q, snap_q;
  logic                  oe_q;
  logic                  rise, fall, cs_fall, cs_rise;

  assign rise    = cs_active & sck_s & ~sck_d;
  assign fall    = cs_active & ~sck_s & sck_d;
  assign cs_fall = ~cs_n_s & cs_n_d;
  assign cs_rise = cs_n_s & ~cs_n_d;

  assign cs_active = ~cs_n_s;
  assign frame_ok  = cs_rise && (cnt_q == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d     <= 1'b0;
      cs_n_d    <= 1'b1;
      seen_rise <= 1'b0;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      snap_q    <= '0;
      oe_q      <= 1'b0;
    end else begin
      sck_d  <= sck_s;
      cs_n_d <= cs_n_s;
      oe_q   <= cs_active;
      if (cs_fall) begin
        cnt_q     <= '0;
        seen_rise <= 1'b0;
        tx_q      <= status_in;
        snap_q    <= status_in;
      end else begin
        if (rise) begin
          rx_q      <= {rx_q[FRAME_BITS-2:0], mosi_s};
          seen_rise <= 1'b1;
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        if (fall && seen_rise) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign rx_byte = rx_q;
  assign snap    = snap_q;
  assign miso    = tx_q[FRAME_BITS-1];
  assign miso_oe = oe_q;
endmodule

// File: rtl/dcsc_reg_bank.sv
module dcsc_reg_bank
  import dcsc_pkg::*;
#(
  parameter int NUM_CARDS = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            commit,
  input  logic [FRAME_BITS-1:0]           cmd_byte,
  input  logic                            strap,
  output logic [NUM_CARDS*DATA_W-1:0]     card_cfg,
  output logic                            card_sel,
  output logic                            sync_mode,
  output gcfg_t                           gcfg
);
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] data;
  logic              async_hit, sync_hit, card_wr, gcfg_wr;

  assign cmd       = cmd_byte[FRAME_BITS-1 -: CMD_W];
  assign data      = cmd_byte[DATA_W-1:0];
  assign async_hit = ~cmd[2] & (cmd[1] == strap);
  assign sync_hit  = cmd[2] & cmd[1];
  assign card_wr   = commit & (async_hit | sync_hit);
  assign gcfg_wr   = commit & (cmd == CMD_GCFG);

  for (genvar g = 0; g < NUM_CARDS; g++) begin : g_card
    logic [DATA_W-1:0] cfg_q;
    always_ff @(posedge clk) begin
      if (rst)                                  cfg_q <= '0;
      else if (card_wr && (32'(cmd[0]) == g))   cfg_q <= data;
    end
    assign card_cfg[g*DATA_W +: DATA_W] = cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      card_sel  <= 1'b0;
      sync_mode <= 1'b0;
      gcfg      <= '0;
    end else begin
      if (card_wr) begin
        card_sel  <= cmd[0];
        sync_mode <= cmd[2];
      end
      if (gcfg_wr) gcfg <= gcfg_t'(data[2:0]);
    end
  end
endmodule

// File: rtl/dcsc_irq_tracker.sv
module dcsc_irq_tracker #(
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                read_done,
  input  logic [STATUS_W-1:0] delivered,
  input  logic [STATUS_W-1:0] status_in,
  output logic                irq
);
  logic [STATUS_W-1:0] ref_q, ref_next;
  logic                irq_q;

  assign ref_next = read_done ? delivered : ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ref_q <= ref_next;
      irq_q <= (status_in != ref_next);
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/dcsc_cmd_decoder.sv
module dcsc_cmd_decoder
  import dcsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sck,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  input  logic                  strap_addr,
  input  logic [FRAME_BITS-1:0] status_in,
  output logic                  spi_miso,
  output logic                  spi_miso_oe,
  output logic [DATA_W-1:0]     card_a_cfg,
  output logic [DATA_W-1:0]     card_b_cfg,
  output logic                  card_sel,
  output logic                  sync_mode,
  output logic                  det_pol,
  output logic                  spi_special,
  output logic                  slope_fast,
  output logic                  irq
);
  localparam int NUM_CARDS = 2;

  logic [2:0]                      pins_s;
  logic                            cs_active, frame_ok;
  logic [FRAME_BITS-1:0]           rx_byte, snap;
  logic [NUM_CARDS*DATA_W-1:0]     card_cfg;
  gcfg_t                           gcfg;

  dcsc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sck, spi_cs_n, spi_mosi}),
    .q(pins_s)
  );

  dcsc_spi_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst(rst),
    .sck_s(pins_s[2]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[0]),
    .status_in(status_in),
    .cs_active(cs_active), .frame_ok(frame_ok),
    .rx_byte(rx_byte), .snap(snap),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  dcsc_reg_bank #(.NUM_CARDS(NUM_CARDS)) u_regs (
    .clk(clk), .rst(rst),
    .commit(frame_ok), .cmd_byte(rx_byte), .strap(strap_addr),
    .card_cfg(card_cfg), .card_sel(card_sel), .sync_mode(sync_mode),
    .gcfg(gcfg)
  );

  dcsc_irq_tracker #(.STATUS_W(FRAME_BITS)) u_irq (
    .clk(clk), .rst(rst),
    .read_done(frame_ok), .delivered(snap), .status_in(status_in),
    .irq(irq)
  );

  assign card_a_cfg  = card_cfg[0 +: DATA_W];
  assign card_b_cfg  = card_cfg[DATA_W +: DATA_W];
  assign det_pol     = gcfg.det_pol;
  assign spi_special = gcfg.spi_special;
  assign slope_fast  = gcfg.slope_fast;
endmodule

// File: rtl/dcsc_cmd_decoder_chk.sv
module dcsc_cmd_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_active,
  input logic       frame_ok,
  input logic [7:0] rx_byte,
  input logic       strap_addr,
  input logic [4:0] card_a_cfg,
  input logic [4:0] card_b_cfg,
  input logic       card_sel,
  input logic       sync_mode,
  input logic       det_pol,
  input logic       spi_special,
  input logic       slope_fast
);
  // R10: nothing commits while chip select is held low
  a_r10_hold_while_selected: assert property (@(posedge clk) disable iff (rst)
    cs_active |=> ($stable(card_a_cfg) && $stable(card_b_cfg) && $stable(card_sel)
                   && $stable(sync_mode) && $stable(det_pol) && $stable(spi_special)
                   && $stable(slope_fast)));

  // R3: a foreign-address card command leaves the cards alone
  a_r3_foreign_address: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && !rx_byte[7] && (rx_byte[6] != strap_addr))
      |=> ($stable(card_a_cfg) && $stable(card_b_cfg) && $stable(card_sel) && $stable(sync_mode)));

  // R5: command 100 has no effect
  a_r5_nop_command: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && (rx_byte[7:5] == 3'b100))
      |=> ($stable(card_a_cfg) && $stable(card_b_cfg) && $stable(card_sel) && $stable(sync_mode)
           && $stable(det_pol) && $stable(spi_special) && $stable(slope_fast)));

  // R6: global configuration leaves the card registers unchanged
  a_r6_gcfg_spares_cards: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && (rx_byte[7:5] == 3'b101))
      |=> ($stable(card_a_cfg) && $stable(card_b_cfg) && (det_pol == $past(rx_byte[0]))));

  // R4: synchronous-card commands ignore the strap
  a_r4_sync_write: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && (rx_byte[7:6] == 2'b11))
      |=> (sync_mode && (card_sel == $past(rx_byte[5]))));
endmodule

bind dcsc_cmd_decoder dcsc_cmd_decoder_chk u_chk (
  .clk(clk), .rst(rst), .cs_active(cs_active), .frame_ok(frame_ok),
  .rx_byte(rx_byte), .strap_addr(strap_addr),
  .card_a_cfg(card_a_cfg), .card_b_cfg(card_b_cfg),
  .card_sel(card_sel), .sync_mode(sync_mode),
  .det_pol(det_pol), .spi_special(spi_special), .slope_fast(slope_fast)
);

// File: tb/dcsc_cmd_decoder_tb.sv
module dcsc_cmd_decoder_tb;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, strap_addr = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic       spi_miso, spi_miso_oe, card_sel, sync_mode, det_pol, spi_special, slope_fast, irq;
  logic [4:0] card_a_cfg, card_b_cfg;

  int n_cmp = 0, n_bad = 0;

  logic [4:0] e_a = '0, e_b = '0;
  logic       e_sel = 0, e_sync = 0, e_pol = 0, e_spec = 0, e_slope = 0;
  logic [7:0] e_ref = '0;

  always #2.5 clk = ~clk;

  dcsc_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .strap_addr(strap_addr), .status_in(status_in),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .card_a_cfg(card_a_cfg), .card_b_cfg(card_b_cfg),
    .card_sel(card_sel), .sync_mode(sync_mode),
    .det_pol(det_pol), .spi_special(spi_special), .slope_fast(slope_fast), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected effect of a committed byte, per R2..R6
  task automatic model(input logic [7:0] b, input logic s);
    logic [2:0] c;
    c = b[7:5];
    if ((!c[2] && (c[1] == s)) || (c[2:1] == 2'b11)) begin
      if (c[0]) e_b = b[4:0]; else e_a = b[4:0];
      e_sel  = c[0];
      e_sync = c[2];
    end else if (c == 3'b101) begin
      e_pol   = b[0];
      e_spec  = b[1];
      e_slope = b[2];
    end
  endtask

  task automatic check_outputs(input string req);
    check({req, " card_a"}, 32'(card_a_cfg), 32'(e_a));
    check({req, " card_b"}, 32'(card_b_cfg), 32'(e_b));
    check({req, " sel/sync"}, {30'd0, card_sel, sync_mode}, {30'd0, e_sel, e_sync});
    check({req, " gcfg"}, {29'd0, det_pol, spi_special, slope_fast}, {29'd0, e_pol, e_spec, e_slope});
  endtask

  // one frame; idle_hi selects serial-clock idle level; flip_mid changes status mid-frame
  task automatic frame(input logic [7:0] b, input int nbits, input logic idle_hi,
                       input logic [7:0] flip_mid, input bit hold_low);
    logic [7:0] snap;
    spi_sck = idle_hi;
    wait_clk(HALF);
    snap = status_in;
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_sck  = 1'b0;
      spi_mosi = (i < 8) ? b[7-i] : 1'b0;
      wait_clk(HALF);
      if (i < 8) check("R8 miso bit", 32'(spi_miso), 32'(snap[7-i]));
      if (i == 0) check("R8 oe while selected", 32'(spi_miso_oe), 32'd1);
      if (i == 3) status_in = status_in ^ flip_mid;
      spi_sck = 1'b1;
      wait_clk(HALF);
    end
    if (!idle_hi) spi_sck = 1'b0;
    wait_clk(HALF);
    if (hold_low) begin
      wait_clk(20);
      check_outputs("R10 held low");
    end
    spi_cs_n = 1'b1;
    wait_clk(10);
    check("R8 oe released", 32'(spi_miso_oe), 32'd0);
    if (nbits == 8) begin
      model(b, strap_addr);
      e_ref = snap;
    end
  endtask

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int nb;
    void'($urandom(32'd1234));
    wait_clk(10);
    check_outputs("R1 reset");
    check("R1 oe", 32'(spi_miso_oe), 0);
    check("R1 irq", 32'(irq), 0);
    rst = 1'b0;
    wait_clk(4);
    check("R1 irq after reset", 32'(irq), 0);

    // R2 async writes, strap 0
    status_in = 8'hA5;
    frame(8'b000_10110, 8, 1'b0, 8'h00, 1'b0); check_outputs("R2 card A");
    frame(8'b001_01001, 8, 1'b1, 8'h00, 1'b0); check_outputs("R2 card B idle high");
    // R3 foreign address
    frame(8'b010_11111, 8, 1'b0, 8'h00, 1'b0); check_outputs("R3 foreign");
    check("R3 card_a kept", 32'(card_a_cfg), 32'h16);
    // R4 sync commands with other strap
    strap_addr = 1'b1;
    frame(8'b110_00011, 8, 1'b0, 8'h00, 1'b0); check_outputs("R4 sync A");
    check("R4 sync_mode", 32'(sync_mode), 1);
    // R5 no-op
    frame(8'b100_11111, 8, 1'b1, 8'h00, 1'b0); check_outputs("R5 nop");
    // R6 global config
    frame(8'b101_00101, 8, 1'b0, 8'h00, 1'b0); check_outputs("R6 gcfg");
    check("R6 det_pol", 32'(det_pol), 1);
    // R7 short and long frames
    frame(8'b011_10000, 7, 1'b0, 8'h00, 1'b0); check_outputs("R7 short");
    frame(8'b011_10000, 9, 1'b1, 8'h00, 1'b0); check_outputs("R7 long");
    // R10 hold chip select low after eight bits
    frame(8'b011_01110, 8, 1'b0, 8'h00, 1'b1); check_outputs("R10 after rise");
    // R9 irq behaviour
    check("R9 irq clear after read", 32'(irq), 0);
    status_in = 8'hA4;
    wait_clk(4);
    check("R9 irq on fault change", 32'(irq), 1);
    frame(8'b100_00000, 7, 1'b0, 8'h00, 1'b0);
    check("R9 R7 short frame keeps irq", 32'(irq), 1);
    frame(8'b100_00000, 8, 1'b0, 8'h01, 1'b0);
    check("R9 change mid-frame survives read", 32'(irq), 1);
    frame(8'b100_00000, 8, 1'b1, 8'h00, 1'b0);
    check("R9 read clears", 32'(irq), 0);
    // status change in the same step as chip select rising
    spi_sck = 1'b0; wait_clk(HALF); spi_cs_n = 1'b0; wait_clk(HALF);
    for (int i = 0; i < 8; i++) begin
      spi_sck = 1'b0; spi_mosi = 1'b1; wait_clk(HALF); spi_sck = 1'b1; wait_clk(HALF);
    end
    spi_sck = 1'b0; wait_clk(HALF);
    e_ref = status_in;
    spi_cs_n = 1'b1; status_in = 8'h3C;
    model(8'hFF, strap_addr);
    wait_clk(10);
    check("R9 change at commit", 32'(irq), 1);
    check_outputs("R4 directed ff");

    // random frames
    for (int k = 0; k < 70; k++) begin
      b = 8'($urandom);
      nb = ($urandom % 6 == 0) ? (($urandom % 2 == 0) ? 7 : 9) : 8;
      strap_addr = 1'($urandom);
      status_in  = 8'($urandom);
      frame(b, nb, 1'($urandom), 8'h00, 1'b0);
      check_outputs("R2 R3 R4 R5 R6 R7 random");
      check("R9 random irq", 32'(irq), 32'(status_in != e_ref));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule